// File: doc/BRIEF.md
# Add-Subtract Unit with Condition Flags

This block is the add and subtract part of a 32-bit integer datapath. In a single combinational pass it computes one of five operations: plain add, add with carry, plain subtract, subtract with carry, and negation (zero minus the first operand). It also computes the next negative, zero, carry and overflow flags. A small flag register keeps the four flags between operations. That register supplies the carry that the carry-chained operations consume, so wide integers can be added or subtracted one 32-bit word per cycle.

Plain add and plain subtract take their second operand from either a register value or an immediate. They write the flags only when the caller asks for it. The carry-chained operations and negation always write the flags. Every subtracting operation reports carry as "no borrow".

Top module: `asu_core`

## Requirements
- R1: With `op_i` = 0 (add), `result_o` equals `src_a_i` plus the second operand modulo 2^32. The second operand is `imm_i` when `use_imm_i` is 1 and `src_b_i` otherwise.
- R2: With `op_i` = 2 (subtract), `result_o` equals `src_a_i` minus the second operand modulo 2^32. The second operand is selected as in R1.
- R3: With `op_i` = 1 (add with carry), `result_o` equals `src_a_i` + `src_b_i` + the stored carry flag. `imm_i` is ignored.
- R4: With `op_i` = 3 (subtract with carry), `result_o` equals `src_a_i` + ~`src_b_i` + the stored carry flag. One extra is deducted when carry is clear. `imm_i` is ignored.
- R5: With `op_i` = 4 (negate), `result_o` equals 0 minus `src_a_i`. `src_b_i` and `imm_i` are ignored. Codes 5 to 7 behave as add.
- R6: Flags are packed as {N,Z,C,V} in bits [3:0]. N is bit 31 of the result. Z is 1 exactly when the result is zero.
- R7: For adds, C is the unsigned carry out of bit 31. For subtract, subtract with carry and negate, C is 1 when no borrow occurs.
- R8: V is 1 when the signed result of the operation does not fit in 32 bits.
- R9: Add and subtract write the flags only when `set_flags_i` is 1. Add with carry, subtract with carry and negate write them regardless of `set_flags_i`.
- R10: `flags_o` is 0 after reset. It takes the value of `flags_nxt_o` on a rising clock edge only when a flag write is due, and holds otherwise.
- R11: Negating 0 gives 0 with C=1 and V=0. Negating 0x80000000 gives 0x80000000 with V=1 and C=0.
- R12: When no flag write is due, `flags_nxt_o` equals `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 negate) |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 32 | Immediate second operand |
| use_imm_i | input | 1 | Select `imm_i` as second operand of add and subtract |
| set_flags_i | input | 1 | Request a flag write for add and subtract |
| result_o | output | 32 | Arithmetic result |
| flags_nxt_o | output | 4 | Next flags {N,Z,C,V} |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
Within one cycle, a carry-chained operation reads the stored carry while that same operation's flag write is prepared for the coming edge. Back-to-back add-with-carry and subtract-with-carry words of 64-bit sums and differences provoke this. A plain flagless add placed in between must leave the carry untouched. The scoreboard keeps its own flag model, updated only at edges where a write is due. It judges each word against the carry left by the previous word, never against the carry being produced.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_RSB = 3'd4
  } asu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } asu_flags_t;

  localparam int unsigned FLAG_W = $bits(asu_flags_t);

endpackage

// File: rtl/asu_operand_sel.sv
module asu_operand_sel
  import asu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_imm_i,
  input  logic         carry_i,
  output logic [W-1:0] add_x_o,
  output logic [W-1:0] add_y_o,
  output logic         add_cin_o,
  output logic         is_sub_o,
  output logic         force_we_o
);

  logic [W-1:0] second_op;

  always_comb begin
    second_op = use_imm_i ? imm_i : src_b_i;
    add_x_o    = src_a_i;
    add_y_o    = second_op;
    add_cin_o  = 1'b0;
    is_sub_o   = 1'b0;
    force_we_o = 1'b0;
    case (op_i)
      OP_ADC: begin
        add_y_o    = src_b_i;
        add_cin_o  = carry_i;
        force_we_o = 1'b1;
      end
      OP_SUB: begin
        add_y_o   = ~second_op;
        add_cin_o = 1'b1;
        is_sub_o  = 1'b1;
      end
      OP_SBC: begin
        add_y_o    = ~src_b_i;
        add_cin_o  = carry_i;
        is_sub_o   = 1'b1;
        force_we_o = 1'b1;
      end
      OP_RSB: begin
        add_x_o    = '0;
        add_y_o    = ~src_a_i;
        add_cin_o  = 1'b1;
        is_sub_o   = 1'b1;
        force_we_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/asu_adder.sv
module asu_adder
  import asu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output asu_flags_t   flags_o
);

  localparam int unsigned SW = W + 1;

  function automatic logic [SW-1:0] wide_add(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic cin);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic sign_overflow(input logic xs, input logic ys,
                                         input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [SW-1:0] wide_sum;

  always_comb begin
    wide_sum  = wide_add(x_i, y_i, cin_i);
    sum_o     = wide_sum[W-1:0];
    flags_o.n = wide_sum[W-1];
    flags_o.z = (wide_sum[W-1:0] == '0);
    flags_o.c = wide_sum[W];
    flags_o.v = sign_overflow(x_i[W-1], y_i[W-1], wide_sum[W-1]);
  end

endmodule

// File: rtl/asu_flag_reg.sv
module asu_flag_reg
  import asu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  asu_flags_t d_i,
  output asu_flags_t q_o
);

  asu_flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (we_i) flags_q <= d_i;
  end

  assign q_o = flags_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(flags_q)); // R10

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (flags_q == $past(d_i))); // R10

endmodule

// File: rtl/asu_core.sv
module asu_core
  import asu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  input  logic [W-1:0] imm_i,
  input  logic         use_imm_i,
  input  logic         set_flags_i,
  output logic [W-1:0] result_o,
  output logic [FLAG_W-1:0] flags_nxt_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [W-1:0] add_x, add_y, sum;
  logic         add_cin, is_sub, force_we;
  logic         flag_we;
  asu_flags_t   cur_flags, calc_flags, nxt_flags;

  asu_operand_sel #(.W(W)) u_opsel (
    .op_i       (op_i),
    .src_a_i    (src_a_i),
    .src_b_i    (src_b_i),
    .imm_i      (imm_i),
    .use_imm_i  (use_imm_i),
    .carry_i    (cur_flags.c),
    .add_x_o    (add_x),
    .add_y_o    (add_y),
    .add_cin_o  (add_cin),
    .is_sub_o   (is_sub),
    .force_we_o (force_we)
  );

  asu_adder #(.W(W)) u_adder (
    .x_i     (add_x),
    .y_i     (add_y),
    .cin_i   (add_cin),
    .sum_o   (sum),
    .flags_o (calc_flags)
  );

  assign flag_we   = force_we | set_flags_i;
  assign nxt_flags = flag_we ? calc_flags : cur_flags;

  asu_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (flag_we),
    .d_i   (nxt_flags),
    .q_o   (cur_flags)
  );

  assign result_o    = sum;
  assign flags_nxt_o = nxt_flags;
  assign flags_o     = cur_flags;

  AST_CHAIN_OPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADC || op_i == OP_SBC || op_i == OP_RSB) |-> flag_we); // R9

  AST_NXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |-> (flags_nxt_o == flags_o)); // R12

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (nxt_flags.z == (result_o == '0))); // R6

  AST_MIXED_SIGN_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && add_x[W-1] != add_y[W-1]) |-> !nxt_flags.v); // R8

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RSB && src_a_i == '0) |-> (result_o == '0 && nxt_flags.c && !nxt_flags.v)); // R11

  AST_SUB_NO_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SUB && !use_imm_i && set_flags_i && src_a_i >= src_b_i) |-> nxt_flags.c); // R7

endmodule

// File: tb/asu_core_bench.sv
module asu_core_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    op;
  logic [W-1:0]  a, b, imm;
  logic          use_imm, setf;
  logic [W-1:0]  result;
  logic [3:0]    nxt, fl;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model_flags = 4'h0;
  int cycles = 0;
  bit done = 0;

  typedef struct {
    logic [W-1:0] res;
    logic [3:0]   nxt;
    logic [3:0]   cur;
    bit           we;
    string        tag;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;

  asu_core #(.W(W)) u_asu_core (
    .clk(clk), .rst_n(rst_n), .op_i(op), .src_a_i(a), .src_b_i(b),
    .imm_i(imm), .use_imm_i(use_imm), .set_flags_i(setf),
    .result_o(result), .flags_nxt_o(nxt), .flags_o(fl)
  );

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one operation and queues the expected outcome.
  task automatic do_op(input logic [2:0] o, input logic [W-1:0] va,
                       input logic [W-1:0] vb, input logic [W-1:0] vi,
                       input bit ui, input bit sf, input string tag);
    item_t it;
    logic [63:0] ua, ub, ur;
    longint sa, sb2, sr;
    logic c_in, cout, ovf;
    logic [W-1:0] r, opnd;
    bit we;
    @(negedge clk);
    op = o; a = va; b = vb; imm = vi; use_imm = ui; setf = sf;
    c_in = model_flags[1];
    ua = {32'b0, va};
    sa = longint'($signed(va));
    opnd = (o == 3'd1 || o == 3'd3) ? vb : (ui ? vi : vb);
    ub = {32'b0, opnd};
    sb2 = longint'($signed(opnd));
    we = sf;
    case (o)
      3'd1: begin ur = ua + ub + c_in; cout = ur[32]; sr = sa + sb2 + c_in; we = 1; end
      3'd2: begin cout = (ua >= ub); sr = sa - sb2; end
      3'd3: begin cout = (ua >= ub + {63'b0, ~c_in}); sr = sa - sb2 - (c_in ? 0 : 1); we = 1; end
      3'd4: begin cout = (va == 0); sr = -sa; we = 1; end
      default: begin ur = ua + ub; cout = ur[32]; sr = sa + sb2; end
    endcase
    r = sr[31:0];
    ovf = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    it.res = r;
    it.cur = model_flags;
    it.nxt = we ? {r[31], r == 0, cout, ovf} : model_flags;
    it.we  = we;
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    model_flags = it.nxt;
  endtask

  // Monitor: compares outputs just after each driven change.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(result == it.res, it.tag, result, it.res);
        check(nxt[3] == it.nxt[3] && nxt[2] == it.nxt[2], "R6 N/Z", {28'b0, nxt}, {28'b0, it.nxt});
        check(nxt[1] == it.nxt[1], "R7 C", {31'b0, nxt[1]}, {31'b0, it.nxt[1]});
        check(nxt[0] == it.nxt[0], "R8 V", {31'b0, nxt[0]}, {31'b0, it.nxt[0]});
        if (!it.we) check(nxt == fl, "R12 hold", {28'b0, nxt}, {28'b0, fl});
        check(fl == it.cur, "R10 R9 stored flags", {28'b0, fl}, {28'b0, it.cur});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    op = 0; a = 0; b = 0; imm = 0; use_imm = 0; setf = 0;
    repeat (3) @(posedge clk);
    #1 check(fl == 4'h0, "R10 reset", {28'b0, fl}, 32'h0);
    rst_n = 1'b1;
    // R1 register and immediate, with and without flag write
    do_op(3'd0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFF, 0, 0, "R1");
    do_op(3'd0, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFB, 1, 1, "R1");
    do_op(3'd0, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0, 0, 1, "R1");
    do_op(3'd0, 32'h1234_5678, 32'h1111_1111, 32'h0, 0, 0, "R9 R1");
    // R2
    do_op(3'd2, 32'h10, 32'h10, 32'h0, 0, 1, "R2");
    do_op(3'd2, 32'h10, 32'h0, 32'h11, 1, 1, "R2");
    do_op(3'd2, 32'h8000_0000, 32'h1, 32'h0, 0, 1, "R2");
    do_op(3'd2, 32'h5, 32'h3, 32'h0, 0, 0, "R9 R2");
    // 64-bit add chained: R3
    do_op(3'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 0, 1, "R1");
    do_op(3'd0, 32'h1, 32'h1, 32'h0, 0, 0, "R9");
    do_op(3'd1, 32'h0000_0001, 32'h0000_0002, 32'hDEAD_BEEF, 1, 0, "R3");
    do_op(3'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 0, 0, "R3");
    // 64-bit subtract chained: R4
    do_op(3'd2, 32'h0, 32'h1, 32'h0, 0, 1, "R2");
    do_op(3'd3, 32'h5, 32'h2, 32'hFFFF, 1, 0, "R4");
    do_op(3'd3, 32'h0, 32'h0, 32'h0, 0, 0, "R4");
    do_op(3'd3, 32'h8000_0000, 32'h1, 32'h0, 0, 0, "R4");
    // R5 / R11 negate
    do_op(3'd4, 32'h0, 32'h55, 32'h66, 1, 0, "R11 R5");
    do_op(3'd4, 32'h8000_0000, 32'h0, 32'h0, 0, 0, "R11 R5");
    do_op(3'd4, 32'h1, 32'hFFFF_FFFF, 32'h0, 0, 0, "R5");
    do_op(3'd5, 32'h3, 32'h4, 32'h0, 0, 1, "R5 undefined");
    for (int i = 0; i < 60; i++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 4));
      do_op(ro, $urandom(), $urandom(), $urandom(), 1'($urandom()), 1'($urandom()),
            ro == 0 ? "R1" : ro == 1 ? "R3" : ro == 2 ? "R2" : ro == 3 ? "R4" : "R5");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule